// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block makes a reader-facing load waveform that imitates a 44-bit proximity tag. Each rising edge of an external sample clock gives one new value on `coil_open`. A 1 leaves the coil open and a 0 shorts it. The frame is built from two subcarrier units. The slow unit is the 8-sample pattern 11000000 repeated six times. The fast unit is the 10-sample pattern 1110000000 repeated five times.

Each frame has three parts, in this order:
1. A single 8-sample separator.
2. A start marker made of units that break the Manchester rules.
3. The ID, most significant bit first, one Manchester symbol per bit, with a separator in front of every group of four bits.

The frame repeats with no gap for as long as the block is enabled. The sequencer works out every sample on the fly from a few small counters, so no sample memory is needed.

Software places bits 43..32 of the ID in the low 12 bits of `id_hi` and bits 31..0 in `id_lo`. The block starts when `enable` is high, `stop` is low and the upper bits of `id_hi` are all zero. It takes a copy of the ID at that moment. `frame_start` marks the first sample of every repetition.

Top module: `fsk_tag_gen`

## Requirements
- R1: While idle, including directly after reset, `coil_open` is 1 and `frame_start` is 0.
- R2: `smp_clk` passes through a two-flop synchroniser. While running, each rising edge of `smp_clk` updates `coil_open` to the next sample exactly once, no later than 3 `clk` cycles after the edge. Between edges, `coil_open` holds its value.
- R3: Each frame opens with one separator: the 8 samples 1,1,0,0,0,0,0,0.
- R4: After the opening separator comes a start marker of eight units, in this order: slow, slow, slow, fast, fast, fast, slow, fast.
- R5: A slow unit is 48 samples, six repeats of 11000000. A fast unit is 50 samples, five repeats of 1110000000.
- R6: A logical 1 is sent as a fast unit followed by a slow unit. A logical 0 is sent as a slow unit followed by a fast unit.
- R7: The ID bits go out from bit 43 down to bit 0. Bits 43..32 are `id_hi[11:0]` and bits 31..0 are `id_lo`.
- R8: One 11000000 separator is placed before each of ID bits 43, 39, 35, ..., 3.
- R9: A frame is 4800 samples long. Sample 0 of the next frame follows the last sample of the previous frame with no gap.
- R10: `frame_start` is high for exactly one `clk` cycle. That cycle is the one in which sample 0 of a repetition appears on `coil_open`. It is never high at any other time.
- R11: If any bit of `id_hi[31:12]` is set, the block does not start. It stays idle, with the coil open and no `frame_start`.
- R12: A high `stop`, or a low `enable`, returns the block to idle after the next `clk` edge, with the coil open. A later start always begins at sample 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request, level sensitive |
| stop | input | 1 | Forces the block idle; takes priority over enable |
| id_hi | input | 32 | ID bits 43..32 in [11:0]; the upper bits must be zero |
| id_lo | input | 32 | ID bits 31..0 |
| smp_clk | input | 1 | Asynchronous sample clock; one sample per rising edge |
| coil_open | output | 1 | 1 = coil open, 0 = coil shorted |
| frame_start | output | 1 | One-cycle pulse with sample 0 of each frame |

## Verification
The bench compares whole frames and their wrap-around against a sample list that it builds independently.

The corner cases it targets, and how a faulty design would show up:
- **Marker order.** A wrong unit in the marker shifts every sample after sample 8, which triggers a long run of mismatches.
- **Separator placement.** A separator at the wrong group boundary stretches the frame, so the samples near bit 32 and at the wrap point no longer line up.
- **Swapped symbol halves.** Exchanging the two halves of a Manchester symbol inverts the data region.
- **Stop.** Stopping on a shorted sample must open the coil on the next clock, and a later restart must begin again at sample 0 with a `frame_start` pulse.
- **Oversized ID.** An ID with high bits set must never produce an edge on `coil_open`.

// File: rtl/fsk_tag_gen.sv
module fsk_tag_gen #(
  parameter int F8_PER   = 8,
  parameter int F8_HIGH  = 2,
  parameter int F8_REPS  = 6,
  parameter int F10_PER  = 10,
  parameter int F10_HIGH = 3,
  parameter int F10_REPS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        stop,
  input  logic [31:0] id_hi,
  input  logic [31:0] id_lo,
  input  logic        smp_clk,
  output logic        coil_open,
  output logic        frame_start
);
  localparam int ID_BITS = 44;
  localparam int HI_BITS = ID_BITS - 32;
  localparam int PW = $clog2(F10_PER);
  localparam int RW = $clog2(F8_REPS + 1);
  localparam logic [7:0] MARK_SEQ = 8'b1011_1000;

  typedef enum logic [1:0] {S_OPEN, S_MARK, S_SEP, S_DATA} seg_t;

  logic [2:0]         sync;
  logic               smp_rise;
  logic               run;
  seg_t               seg;
  logic [2:0]         mark_idx;
  logic [5:0]         bit_idx;
  logic               half;
  logic [PW-1:0]      pos;
  logic [RW-1:0]      rep;
  logic [ID_BITS-1:0] id_r;

  logic          f10, sample, unit_end, first, id_ok;
  logic [PW-1:0] per_m1, high;
  logic [RW-1:0] reps_m1;

  assign smp_rise = sync[1] & ~sync[2];
  assign id_ok    = (id_hi[31:HI_BITS] == '0);

  always_comb begin
    case (seg)
      S_MARK:  f10 = MARK_SEQ[mark_idx];
      S_DATA:  f10 = id_r[bit_idx] ^ half;
      default: f10 = 1'b0;
    endcase
  end

  assign per_m1  = f10 ? PW'(F10_PER - 1) : PW'(F8_PER - 1);
  assign high    = f10 ? PW'(F10_HIGH) : PW'(F8_HIGH);
  assign reps_m1 = (seg == S_OPEN || seg == S_SEP) ? '0 :
                   f10 ? RW'(F10_REPS - 1) : RW'(F8_REPS - 1);
  assign sample   = pos < high;
  assign unit_end = (pos == per_m1) && (rep == reps_m1);
  assign first    = (seg == S_OPEN) && (pos == '0) && (rep == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], smp_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run         <= 1'b0;
      coil_open   <= 1'b1;
      frame_start <= 1'b0;
      seg         <= S_OPEN;
      mark_idx    <= '0;
      bit_idx     <= 6'(ID_BITS - 1);
      half        <= 1'b0;
      pos         <= '0;
      rep         <= '0;
      id_r        <= '0;
    end else begin
      frame_start <= 1'b0;
      if (stop || !enable) begin
        run       <= 1'b0;
        coil_open <= 1'b1;
      end else if (!run) begin
        coil_open <= 1'b1;
        if (id_ok) begin
          run      <= 1'b1;
          id_r     <= {id_hi[HI_BITS-1:0], id_lo};
          seg      <= S_OPEN;
          mark_idx <= '0;
          bit_idx  <= 6'(ID_BITS - 1);
          half     <= 1'b0;
          pos      <= '0;
          rep      <= '0;
        end
      end else if (smp_rise) begin
        coil_open   <= sample;
        frame_start <= first;
        if (!unit_end) begin
          if (pos == per_m1) begin
            pos <= '0;
            rep <= rep + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end else begin
          pos <= '0;
          rep <= '0;
          case (seg)
            S_OPEN: begin
              seg      <= S_MARK;
              mark_idx <= '0;
            end
            S_MARK: begin
              if (mark_idx == 3'd7) seg <= S_SEP;
              else mark_idx <= mark_idx + 1'b1;
            end
            S_SEP: begin
              seg  <= S_DATA;
              half <= 1'b0;
            end
            default: begin
              if (!half) begin
                half <= 1'b1;
              end else begin
                half <= 1'b0;
                if (bit_idx == '0) begin
                  seg     <= S_OPEN;
                  bit_idx <= 6'(ID_BITS - 1);
                end else begin
                  bit_idx <= bit_idx - 1'b1;
                  if (bit_idx[1:0] == 2'b00) seg <= S_SEP;
                end
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fsk_tag_gen_chk.sv
module fsk_tag_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        stop,
  input logic [19:0] id_hi_top,
  input logic        coil_open,
  input logic        frame_start,
  input logic        run,
  input logic        smp_rise
);
  assert_idle_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> coil_open);

  assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stop && !smp_rise) |=> $stable(coil_open));

  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_start_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> run);

  assert_reject_wide_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && id_hi_top != '0) |=> !run);

  assert_stop_idles_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!run && coil_open && !frame_start));
endmodule

bind fsk_tag_gen fsk_tag_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .stop(stop),
  .id_hi_top(id_hi[31:12]), .coil_open(coil_open), .frame_start(frame_start),
  .run(run), .smp_rise(smp_rise)
);

// File: tb/sim_fsk_tag_gen.sv
`timescale 1ns/1ps
module sim_fsk_tag_gen;
  localparam int FRAME = 4800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        stop = 1'b0;
  logic [31:0] id_hi = '0;
  logic [31:0] id_lo = '0;
  logic        smp_clk = 1'b0;
  logic        coil_open;
  logic        frame_start;

  int total = 0;
  int bad = 0;
  int fs_seen = 0;
  bit done = 0;
  int q[$];

  always #2.5 clk = ~clk;

  fsk_tag_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stop(stop),
    .id_hi(id_hi), .id_lo(id_lo), .smp_clk(smp_clk),
    .coil_open(coil_open), .frame_start(frame_start)
  );

  always @(negedge clk) if (frame_start) fs_seen++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      if (bad < 20) $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_pat(input int per, input int hi, input int reps);
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < per; p++) q.push_back(p < hi ? 1 : 0);
  endtask

  task automatic build(input logic [31:0] hi, input logic [31:0] lo);
    int mk[8] = '{8, 8, 8, 10, 10, 10, 8, 10};
    q.delete();
    add_pat(8, 2, 1);
    foreach (mk[k]) begin
      if (mk[k] == 8) add_pat(8, 2, 6);
      else add_pat(10, 3, 5);
    end
    for (int b = 43; b >= 0; b--) begin
      logic bv;
      if (b % 4 == 3) add_pat(8, 2, 1);
      bv = (b >= 32) ? hi[b-32] : lo[b];
      if (bv) begin add_pat(10, 3, 5); add_pat(8, 2, 6); end
      else begin add_pat(8, 2, 6); add_pat(10, 3, 5); end
    end
  endtask

  function automatic string region(input int i);
    if (i >= FRAME) return "R9 wrap";
    if (i < 8) return "R3 opening";
    if (i < 400) return "R4 R5 marker";
    return "R2 R5 R6 R7 R8 data";
  endfunction

  task automatic one_edge();
    @(negedge clk) smp_clk = 1'b1;
    repeat (3) @(negedge clk);
    smp_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_samples(input int from, input int count);
    for (int i = from; i < from + count; i++) begin
      fs_seen = 0;
      one_edge();
      check(region(i), coil_open, q[i % FRAME]);
      check("R10 frame_start", fs_seen, (i % FRAME == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset coil", coil_open, 1);
    check("R1 reset frame_start", frame_start, 0);

    id_hi = 32'h0000_0A5C; id_lo = 32'h9E37_79B9;
    build(id_hi, id_lo);
    check("R9 frame length", q.size(), FRAME);
    enable = 1'b1;
    @(negedge clk);
    run_samples(0, FRAME + 10);

    enable = 1'b0;
    @(negedge clk);
    check("R12 enable low opens coil", coil_open, 1);
    fs_seen = 0;
    for (int k = 0; k < 5; k++) begin
      one_edge();
      check("R1 idle holds open", coil_open, 1);
    end
    check("R1 idle no frame_start", fs_seen, 0);

    id_hi = 32'h0000_03F0; id_lo = 32'h0F0F_A55A;
    build(id_hi, id_lo);
    enable = 1'b1;
    @(negedge clk);
    run_samples(0, FRAME + 6);
    check("R12 precondition shorted", coil_open, 0);
    stop = 1'b1;
    @(negedge clk);
    check("R12 stop opens coil", coil_open, 1);
    fs_seen = 0;
    one_edge();
    check("R12 stopped holds open", coil_open, 1);
    check("R12 stopped no frame_start", fs_seen, 0);
    stop = 1'b0;
    @(negedge clk);
    run_samples(0, 500);

    enable = 1'b0;
    @(negedge clk);
    id_hi = 32'h0000_1ABC; id_lo = 32'h1234_5678;
    enable = 1'b1;
    fs_seen = 0;
    for (int k = 0; k < 30; k++) begin
      one_edge();
      check("R11 wide id stays open", coil_open, 1);
    end
    check("R11 wide id no frame_start", fs_seen, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule